// File: doc/BRIEF.md
# Pipelined Tree Carry Adder

This block adds two unsigned operands of `2**LOG_W` bits plus a carry bit. It does not ripple the carry across the word. Each bit first yields a generate term and a propagate term. A binary tree of merge cells then folds these terms upward, one tree level per clock, until the whole word has one group generate and one group propagate.

The carry travels back down the same tree, again one level per clock. At each node, the lower half receives the node's carry unchanged. The upper half receives the lower half's generate, OR'd with its propagate AND'd with the node's carry. Once every bit holds its own carry, a last stage forms the sum bits and the carry-out. The path is `2*(LOG_W+1)` register stages deep.

Every stage holds a different addition, so a new operand pair can be presented on every clock. A valid flag travels with the data.

Top module: `pipe_tree_adder`

## Requirements
- R1: When `out_valid` is high, `sum` equals the low `2**LOG_W` bits of `a + b + cin`, taken from the inputs that were valid `2*LOG_W+2` cycles earlier.
- R2: When `out_valid` is high, `cout` equals bit `2**LOG_W` of that same total.
- R3: `out_valid` is high in a cycle exactly when `in_valid` was high `2*LOG_W+2` rising edges earlier.
- R4: A new operand pair is accepted on every clock. Back-to-back additions do not disturb each other.
- R5: `out_valid` is low while `rst_n` is low and afterwards, until the first valid input reaches the end of the pipeline. An idle input cycle produces an idle output cycle.
- R6: Full propagate chain: when `b` is the bitwise complement of `a`, the result is zero with `cout` = 1 if `cin` = 1, and all ones with `cout` = 0 if `cin` = 0.
- R7: All-ones plus one (`a` all ones, `b` = 1, `cin` = 0) gives `sum` = 0 and `cout` = 1.
- R8: The carry delivered to each bit `i+1` equals `g[i] | (p[i] & c[i])`, where `g = a & b` and `p = a ^ b` for bit `i`. The carry delivered to bit 0 equals `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid flags |
| in_valid | input | 1 | Operands on this cycle are to be added |
| a | input | 2**LOG_W | First operand |
| b | input | 2**LOG_W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | `sum` and `cout` hold a result |
| sum | output | 2**LOG_W | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder with `LOG_W = 5`. This gives a 32-bit word, a five-level tree and a twelve-stage pipeline, so carries cross every level of the tree in both directions. At that width, the end-to-end propagate chains and the all-ones-plus-one case exercise the longest carry path the tree has. Streams with and without idle cycles show that the valid flag keeps its exact stage count under full and partial load.

// File: rtl/adder_tree_pkg.sv
package adder_tree_pkg;

    // Nodes are stored level by level in one flat vector: the bits first,
    // then each coarser level, with the root last.
    function automatic int lvl_off(input int w, input int lvl);
        return 2 * w - ((2 * w) >> lvl);
    endfunction

    function automatic int lvl_cnt(input int w, input int lvl);
        return w >> lvl;
    endfunction

endpackage

// File: rtl/bit_gp_cell.sv
module bit_gp_cell (
    input  logic x,
    input  logic y,
    output logic g,
    output logic p
);
    assign g = x & y;
    assign p = x ^ y;
endmodule

// File: rtl/gp_merge_cell.sv
module gp_merge_cell (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    input  logic p_lo,
    output logic g_grp,
    output logic p_grp
);
    assign g_grp = g_hi | (p_hi & g_lo);
    assign p_grp = p_hi & p_lo;
endmodule

// File: rtl/carry_split_cell.sv
module carry_split_cell (
    input  logic c_node,
    input  logic g_lo,
    input  logic p_lo,
    output logic c_lo,
    output logic c_hi
);
    assign c_lo = c_node;
    assign c_hi = g_lo | (p_lo & c_node);
endmodule

// File: rtl/pipe_tree_adder.sv
module pipe_tree_adder
    import adder_tree_pkg::*;
#(
    parameter int LOG_W = 5,
    localparam int W = 1 << LOG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic         out_valid,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NODES  = 2 * W - 1;
    localparam int ROOT   = NODES - 1;
    localparam int STAGES = 2 * LOG_W + 2;
    localparam int LAST   = STAGES - 1;

    wire  [NODES-1:0] g_d [1:LAST];
    wire  [NODES-1:0] p_d [1:LAST];
    wire  [NODES-1:0] c_d [1:LAST];
    logic [NODES-1:0] g_q [1:LAST];
    logic [NODES-1:0] p_q [1:LAST];
    logic [NODES-1:0] c_q [1:LAST];
    logic [STAGES:1]  v_q;
    logic [LAST:1]    cin_q;
    logic [W-1:0]     sum_q;
    logic             cout_q;

    // Stage 1: per-bit generate and propagate
    for (genvar i = 0; i < W; i++) begin : g_leaf
        bit_gp_cell u_leaf (
            .x(a[i]), .y(b[i]), .g(g_d[1][i]), .p(p_d[1][i])
        );
    end
    assign g_d[1][NODES-1:W] = '0;
    assign p_d[1][NODES-1:W] = '0;
    assign c_d[1]            = '0;

    // Stages 2 .. LOG_W+1: upward merge, one tree level per stage
    for (genvar s = 2; s <= LOG_W + 1; s++) begin : g_up
        localparam int L = s - 1;
        for (genvar l2 = 0; l2 <= LOG_W; l2++) begin : g_lvl
            if (l2 == L) begin : g_merge
                for (genvar j = 0; j < lvl_cnt(W, L); j++) begin : g_node
                    gp_merge_cell u_merge (
                        .g_hi (g_q[s-1][lvl_off(W, L-1) + 2*j + 1]),
                        .p_hi (p_q[s-1][lvl_off(W, L-1) + 2*j + 1]),
                        .g_lo (g_q[s-1][lvl_off(W, L-1) + 2*j]),
                        .p_lo (p_q[s-1][lvl_off(W, L-1) + 2*j]),
                        .g_grp(g_d[s][lvl_off(W, L) + j]),
                        .p_grp(p_d[s][lvl_off(W, L) + j])
                    );
                end
            end else begin : g_keep
                assign g_d[s][lvl_off(W, l2) +: lvl_cnt(W, l2)] =
                    g_q[s-1][lvl_off(W, l2) +: lvl_cnt(W, l2)];
                assign p_d[s][lvl_off(W, l2) +: lvl_cnt(W, l2)] =
                    p_q[s-1][lvl_off(W, l2) +: lvl_cnt(W, l2)];
            end
        end
        if (s == LOG_W + 1) begin : g_seed
            assign c_d[s][ROOT]        = cin_q[s-1];
            assign c_d[s][ROOT-1:0]    = c_q[s-1][ROOT-1:0];
        end else begin : g_pass
            assign c_d[s] = c_q[s-1];
        end
    end

    // Stages LOG_W+2 .. LAST: downward carry split, one level per stage
    for (genvar s = LOG_W + 2; s <= LAST; s++) begin : g_dn
        localparam int L = 2 * LOG_W + 1 - s;
        assign g_d[s] = g_q[s-1];
        assign p_d[s] = p_q[s-1];
        for (genvar l2 = 0; l2 <= LOG_W; l2++) begin : g_lvl
            if (l2 == L) begin : g_split
                for (genvar j = 0; j < lvl_cnt(W, L + 1); j++) begin : g_node
                    carry_split_cell u_split (
                        .c_node(c_q[s-1][lvl_off(W, L+1) + j]),
                        .g_lo  (g_q[s-1][lvl_off(W, L) + 2*j]),
                        .p_lo  (p_q[s-1][lvl_off(W, L) + 2*j]),
                        .c_lo  (c_d[s][lvl_off(W, L) + 2*j]),
                        .c_hi  (c_d[s][lvl_off(W, L) + 2*j + 1])
                    );
                end
            end else begin : g_keep
                assign c_d[s][lvl_off(W, l2) +: lvl_cnt(W, l2)] =
                    c_q[s-1][lvl_off(W, l2) +: lvl_cnt(W, l2)];
            end
        end
    end

    // Data registers (no reset: the valid flag qualifies them)
    for (genvar s = 1; s <= LAST; s++) begin : g_reg
        always_ff @(posedge clk) begin
            g_q[s] <= g_d[s];
            p_q[s] <= p_d[s];
            c_q[s] <= c_d[s];
        end
    end

    always_ff @(posedge clk) begin
        cin_q <= {cin_q[LAST-1:1], cin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= {v_q[STAGES-1:1], in_valid};
    end

    // Final stage: sum bits and carry-out
    always_ff @(posedge clk) begin
        sum_q  <= p_q[LAST][W-1:0] ^ c_q[LAST][W-1:0];
        cout_q <= g_q[LAST][ROOT] | (p_q[LAST][ROOT] & cin_q[LAST]);
    end

    assign out_valid = v_q[STAGES];
    assign sum       = sum_q;
    assign cout      = cout_q;

    // R8
    carry_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[LAST] |-> (c_q[LAST][0] == cin_q[LAST]));

    for (genvar i = 0; i < W - 1; i++) begin : g_chk
        // R8
        ripple_chk: assert property (@(posedge clk) disable iff (!rst_n)
            v_q[LAST] |-> (c_q[LAST][i+1] ==
                (g_q[LAST][i] | (p_q[LAST][i] & c_q[LAST][i]))));
    end

    // R2
    cout_ripple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cout == $past(g_q[LAST][W-1] |
                                     (p_q[LAST][W-1] & c_q[LAST][W-1]))));

    // R6
    root_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q[LOG_W+1] && p_q[LOG_W+1][ROOT]) |-> !g_q[LOG_W+1][ROOT]);

endmodule

// File: tb/sim_pipe_tree_adder.sv
module sim_pipe_tree_adder;
    localparam int LOG_W = 5;
    localparam int W     = 1 << LOG_W;
    localparam int LAT   = 2 * LOG_W + 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [W-1:0] a, b;
    logic         cin;
    logic         out_valid;
    logic [W-1:0] sum;
    logic         cout;

    always #10 clk = ~clk;

    pipe_tree_adder #(.LOG_W(LOG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a(a), .b(b), .cin(cin),
        .out_valid(out_valid), .sum(sum), .cout(cout)
    );

    typedef struct {
        logic         v;
        logic [W-1:0] s;
        logic         co;
        string        tag;
    } exp_t;

    exp_t pend_q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare the outputs against the entry driven LAT cycles ago
    task automatic compare_out();
        exp_t e;
        if (pend_q.size() == LAT) begin
            e = pend_q.pop_front();
            // R3 / R5: valid timing
            check(out_valid == e.v, e.v ? "R3" : "R5", "out_valid",
                  64'(out_valid), 64'(e.v));
            if (e.v) begin
                // R1 (carry pattern per bit R8)
                check(sum == e.s, {"R1/", e.tag}, "sum", 64'(sum), 64'(e.s));
                // R2
                check(cout == e.co, {"R2/", e.tag}, "cout", 64'(cout), 64'(e.co));
            end
        end else begin
            // R5: no result before the pipeline is filled
            check(out_valid == 1'b0, "R5", "out_valid early", 64'(out_valid), 64'd0);
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic ci, input string tag);
        exp_t         e;
        logic [W:0]   tot;
        @(negedge clk);
        compare_out();
        in_valid = v;
        a        = x;
        b        = y;
        cin      = ci;
        tot      = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        e.v      = v;
        e.s      = tot[W-1:0];
        e.co     = tot[W];
        e.tag    = tag;
        pend_q.push_back(e);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        a        = '0;
        b        = '0;
        cin      = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            // R5: reset state
            check(out_valid == 1'b0, "R5", "out_valid in reset", 64'(out_valid), 64'd0);
        end
        rst_n = 1'b1;

        // R7: all ones plus one
        step(1'b1, '1, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R7");
        step(1'b1, '1, '0, 1'b1, "R7");
        // R6: full propagate chains
        step(1'b1, 32'hA5A5_0F0F, ~32'hA5A5_0F0F, 1'b1, "R6");
        step(1'b1, 32'h1234_5678, ~32'h1234_5678, 1'b0, "R6");
        step(1'b1, '0, '1, 1'b1, "R6");
        step(1'b1, '0, '1, 1'b0, "R6");
        step(1'b1, '0, '0, 1'b0, "R1");
        step(1'b1, '1, '1, 1'b1, "R2");
        step(1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, "R2");

        // R4: back-to-back random stream
        for (int k = 0; k < 400; k++)
            step(1'b1, W'($urandom), W'($urandom), 1'($urandom), "R4");

        // R5: stream with idle cycles
        for (int k = 0; k < 300; k++)
            step(1'($urandom_range(0, 1)), W'($urandom), W'($urandom),
                 1'($urandom), "R5");

        // R6: random propagate chains back to back
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] x;
            x = W'($urandom);
            step(1'b1, x, ~x, 1'($urandom), "R6");
        end

        // Drain
        for (int k = 0; k < LAT + 2; k++)
            step(1'b0, '0, '0, 1'b0, "R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL R4: watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule